// File: doc/BRIEF.md
# Audio Frame Sequencer with Interrupt

This block sets the slow rhythm of a sound generator. It counts qualified cycles, marked by a cycle-enable input, and at a fixed set of uneven counts it emits single-clock "quarter" and "half" strobes. Envelope, linear, length and sweep units outside the block use these strobes as their clocks. The block has two loop lengths, a four-step loop and a five-step loop. Software picks one by writing an 8-bit control word.

In the four-step loop the block can also raise a frame interrupt flag, which drives the IRQ output directly. The flag is set on three consecutive qualified cycles around the loop boundary. An external clear strobe clears it, for example on a status read. A control write with the inhibit bit set also clears it. Every control write restarts the count. A write that selects the five-step loop also performs the first step's strobes at once.

Top module: `snd_frame_seq`

## Requirements
- R1: After a synchronous reset, qtr_o, half_o and irq_o are low. The block is in four-step mode with inhibit clear. No strobe appears until 7459 qualified cycles have elapsed.
- R2: The count advances only on clocks where cyc_en_i is high. Each strobe is high for exactly one clock. That clock follows the edge that ended the qualified cycle reaching the count. With cyc_en_i low, no strobe appears and the flag is not set.
- R3: Four-step mode (control bit 7 = 0): quarter strobes fall at counts 7459, 14915, 22373 and 29830. Half strobes fall at 14915 and 29830. The count then wraps, so the loop is 29830 qualified cycles long.
- R4: Five-step mode (control bit 7 = 1): quarter strobes fall at counts 7459, 14915, 22373 and 37283. Half strobes fall at 7459 and 22373. Count 29829 is a step without strobes. The loop is 37283 qualified cycles long. Every half strobe coincides with a quarter strobe.
- R5: In four-step mode with inhibit clear, the frame flag is set at count 29830 and at counts 1 and 2 of the following loop. irq_o equals the flag.
- R6: The flag is never set in five-step mode, nor while the inhibit bit (control bit 6) is 1.
- R7: A control write (wr_en_i high) loads mode from bit 7 and inhibit from bit 6, restarts the count at 0 and cancels any pending flag-set cycles. The first step then follows 7459 qualified cycles after the write.
- R8: A write that selects five-step mode raises both qtr_o and half_o in the clock after the write.
- R9: A write with bit 6 = 1 clears the flag. A write with bit 6 = 0 leaves the flag unchanged.
- R10: clr_i clears the flag. If a set and clr_i fall on the same clock, the flag stays set.
- R11: The clock of a control write is not counted, even with cyc_en_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_en_i | input | 1 | Qualifies the clock as a counted cycle |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | CTRL_W | Control word: bit 7 mode, bit 6 inhibit, other bits ignored |
| clr_i | input | 1 | Clears the frame flag |
| qtr_o | output | 1 | Quarter-frame strobe |
| half_o | output | 1 | Half-frame strobe |
| irq_o | output | 1 | Frame interrupt flag |

## Verification
The bound checker verifies the local rules on every clock:
- strobes last one clock unless a five-step write renews them;
- a strobe always follows a qualified cycle or a five-step write;
- a half strobe never appears without a quarter strobe;
- a five-step write strobes at once;
- an inhibiting write clears the flag;
- the flag falls only after a clear or an inhibiting write, and never rises in five-step mode.

The exact step counts, the three-cycle flag window across the wrap, the restart distance, set-over-clear priority and the effect of enable gaps depend on long histories. Only the bench's reference model, which tracks every qualified cycle, can show them.

// File: rtl/snd_fseq_pkg.sv
package snd_fseq_pkg;

   typedef enum logic {
      SEQ_FOUR = 1'b0,
      SEQ_FIVE = 1'b1
   } seq_mode_e;

   typedef struct packed {
      seq_mode_e mode;
      logic      inhibit;
   } seq_ctrl_t;

   localparam int FOUR_STEPS = 4;
   localparam int FIVE_STEPS = 5;

   // bit i refers to step i+1
   localparam logic [FOUR_STEPS-1:0] FOUR_QTR_MASK  = 4'b1111;
   localparam logic [FOUR_STEPS-1:0] FOUR_HALF_MASK = 4'b1010;
   localparam logic [FIVE_STEPS-1:0] FIVE_QTR_MASK  = 5'b10111;
   localparam logic [FIVE_STEPS-1:0] FIVE_HALF_MASK = 5'b00101;

endpackage

// File: rtl/snd_fseq_ctrl.sv
module snd_fseq_ctrl
   import snd_fseq_pkg::*;
#(
   parameter int CTRL_W   = 8,
   parameter int MODE_BIT = 7,
   parameter int INH_BIT  = 6
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_en_i,
   input  logic [CTRL_W-1:0] wr_data_i,
   output seq_ctrl_t         ctrl_o,
   output logic              restart_o,
   output logic              wr_five_o,
   output logic              wr_inh_o
);

   seq_ctrl_t ctrl_q;
   logic      data_unused;

   assign data_unused = ^wr_data_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ctrl_q.mode    <= SEQ_FOUR;
         ctrl_q.inhibit <= 1'b0;
      end else if (wr_en_i) begin
         ctrl_q.mode    <= wr_data_i[MODE_BIT] ? SEQ_FIVE : SEQ_FOUR;
         ctrl_q.inhibit <= wr_data_i[INH_BIT];
      end
   end

   assign ctrl_o    = ctrl_q;
   assign restart_o = wr_en_i;
   assign wr_five_o = wr_en_i & wr_data_i[MODE_BIT];
   assign wr_inh_o  = wr_en_i & wr_data_i[INH_BIT];

endmodule

// File: rtl/snd_fseq_counter.sv
module snd_fseq_counter
   import snd_fseq_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int S1      = 7459,
   parameter int S2      = 14915,
   parameter int S3      = 22373,
   parameter int S4_FOUR = 29830,
   parameter int S4_FIVE = 29829,
   parameter int S5_FIVE = 37283
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic step_en_i,
   input  logic restart_i,
   input  logic mode_five_i,
   output logic qtr_hit_o,
   output logic half_hit_o,
   output logic frame_end_o
);

   localparam int POS_FOUR [FOUR_STEPS] = '{S1, S2, S3, S4_FOUR};
   localparam int POS_FIVE [FIVE_STEPS] = '{S1, S2, S3, S4_FIVE, S5_FIVE};

   logic [CNT_W-1:0]      cnt_q;
   logic [CNT_W-1:0]      cnt_nx;
   logic [FOUR_STEPS-1:0] hit_four;
   logic [FIVE_STEPS-1:0] hit_five;
   logic                  last_hit;

   assign cnt_nx = cnt_q + 1'b1;

   for (genvar i = 0; i < FOUR_STEPS; i++) begin : g_four
      assign hit_four[i] = (cnt_nx == CNT_W'(POS_FOUR[i]));
   end

   for (genvar i = 0; i < FIVE_STEPS; i++) begin : g_five
      assign hit_five[i] = (cnt_nx == CNT_W'(POS_FIVE[i]));
   end

   always_comb begin
      if (mode_five_i) begin
         qtr_hit_o  = step_en_i & |(hit_five & FIVE_QTR_MASK);
         half_hit_o = step_en_i & |(hit_five & FIVE_HALF_MASK);
         last_hit   = hit_five[FIVE_STEPS-1];
      end else begin
         qtr_hit_o  = step_en_i & |(hit_four & FOUR_QTR_MASK);
         half_hit_o = step_en_i & |(hit_four & FOUR_HALF_MASK);
         last_hit   = hit_four[FOUR_STEPS-1];
      end
   end

   assign frame_end_o = step_en_i & ~mode_five_i & hit_four[FOUR_STEPS-1];

   always_ff @(posedge clk_i) begin
      if (rst_i || restart_i) begin
         cnt_q <= '0;
      end else if (step_en_i) begin
         cnt_q <= last_hit ? '0 : cnt_nx;
      end
   end

endmodule

// File: rtl/snd_fseq_irq.sv
module snd_fseq_irq #(
   parameter int TAIL_N = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic step_en_i,
   input  logic restart_i,
   input  logic frame_end_i,
   input  logic mode_five_i,
   input  logic inhibit_i,
   input  logic wr_inh_i,
   input  logic clr_i,
   output logic flag_o
);

   localparam int TAIL_W = (TAIL_N > 0) ? $clog2(TAIL_N + 1) : 1;

   logic tail_act;
   logic set_now;
   logic flag_q;

   if (TAIL_N > 0) begin : g_tail
      logic [TAIL_W-1:0] tail_q;
      always_ff @(posedge clk_i) begin
         if (rst_i || restart_i) begin
            tail_q <= '0;
         end else if (step_en_i) begin
            if (frame_end_i) begin
               tail_q <= TAIL_W'(TAIL_N);
            end else if (tail_q != '0) begin
               tail_q <= tail_q - 1'b1;
            end
         end
      end
      assign tail_act = (tail_q != '0);
   end else begin : g_no_tail
      assign tail_act = 1'b0;
   end

   assign set_now = step_en_i & ~mode_five_i & ~inhibit_i & (frame_end_i | tail_act);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         flag_q <= 1'b0;
      end else if (set_now) begin
         flag_q <= 1'b1;
      end else if (clr_i || wr_inh_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/snd_frame_seq.sv
module snd_frame_seq
   import snd_fseq_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int CTRL_W   = 8,
   parameter int MODE_BIT = 7,
   parameter int INH_BIT  = 6,
   parameter int S1       = 7459,
   parameter int S2       = 14915,
   parameter int S3       = 22373,
   parameter int S4_FOUR  = 29830,
   parameter int S4_FIVE  = 29829,
   parameter int S5_FIVE  = 37283,
   parameter int TAIL_N   = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              cyc_en_i,
   input  logic              wr_en_i,
   input  logic [CTRL_W-1:0] wr_data_i,
   input  logic              clr_i,
   output logic              qtr_o,
   output logic              half_o,
   output logic              irq_o
);

   localparam longint CNT_LIMIT = longint'(1) << CNT_W;

   if (!(S1 > 0 && S1 < S2 && S2 < S3 && S3 < S4_FOUR)) begin : g_bad_four
      $error("four-step positions must ascend from above zero");
   end
   if (!(S3 < S4_FIVE && S4_FIVE < S5_FIVE)) begin : g_bad_five
      $error("five-step positions must ascend");
   end
   if (longint'(S5_FIVE) >= CNT_LIMIT || longint'(S4_FOUR) >= CNT_LIMIT) begin : g_bad_width
      $error("CNT_W too narrow for the step positions");
   end
   if (MODE_BIT >= CTRL_W || INH_BIT >= CTRL_W || MODE_BIT == INH_BIT) begin : g_bad_bits
      $error("control bit positions invalid");
   end
   if (TAIL_N < 0 || TAIL_N >= S1) begin : g_bad_tail
      $error("TAIL_N out of range");
   end

   seq_ctrl_t ctrl;
   logic      restart;
   logic      wr_five;
   logic      wr_inh;
   logic      step_en;
   logic      mode_five;
   logic      qtr_hit;
   logic      half_hit;
   logic      frame_end;
   logic      qtr_q;
   logic      half_q;

   snd_fseq_ctrl #(
      .CTRL_W   (CTRL_W),
      .MODE_BIT (MODE_BIT),
      .INH_BIT  (INH_BIT)
   ) u_ctrl (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .ctrl_o    (ctrl),
      .restart_o (restart),
      .wr_five_o (wr_five),
      .wr_inh_o  (wr_inh)
   );

   assign step_en   = cyc_en_i & ~restart;
   assign mode_five = (ctrl.mode == SEQ_FIVE);

   snd_fseq_counter #(
      .CNT_W   (CNT_W),
      .S1      (S1),
      .S2      (S2),
      .S3      (S3),
      .S4_FOUR (S4_FOUR),
      .S4_FIVE (S4_FIVE),
      .S5_FIVE (S5_FIVE)
   ) u_cnt (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .step_en_i   (step_en),
      .restart_i   (restart),
      .mode_five_i (mode_five),
      .qtr_hit_o   (qtr_hit),
      .half_hit_o  (half_hit),
      .frame_end_o (frame_end)
   );

   snd_fseq_irq #(
      .TAIL_N (TAIL_N)
   ) u_irq (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .step_en_i   (step_en),
      .restart_i   (restart),
      .frame_end_i (frame_end),
      .mode_five_i (mode_five),
      .inhibit_i   (ctrl.inhibit),
      .wr_inh_i    (wr_inh),
      .clr_i       (clr_i),
      .flag_o      (irq_o)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         qtr_q  <= 1'b0;
         half_q <= 1'b0;
      end else begin
         qtr_q  <= qtr_hit | wr_five;
         half_q <= half_hit | wr_five;
      end
   end

   assign qtr_o  = qtr_q;
   assign half_o = half_q;

endmodule

// File: rtl/snd_frame_seq_chk.sv
module snd_frame_seq_chk #(
   parameter int CTRL_W   = 8,
   parameter int MODE_BIT = 7,
   parameter int INH_BIT  = 6
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              cyc_en_i,
   input logic              wr_en_i,
   input logic [CTRL_W-1:0] wr_data_i,
   input logic              clr_i,
   input logic              qtr_o,
   input logic              half_o,
   input logic              irq_o
);

   logic five_seen;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         five_seen <= 1'b0;
      end else if (wr_en_i) begin
         five_seen <= wr_data_i[MODE_BIT];
      end
   end

   a_r2_strobe_one_clock: assert property (@(posedge clk_i) disable iff (rst_i)
      qtr_o |=> (!qtr_o || $past(wr_en_i)));

   a_r11_strobe_cause: assert property (@(posedge clk_i) disable iff (rst_i)
      qtr_o |-> ($past(cyc_en_i) || $past(wr_en_i && wr_data_i[MODE_BIT])));

   a_r4_half_has_qtr: assert property (@(posedge clk_i) disable iff (rst_i)
      half_o |-> qtr_o);

   a_r8_five_immediate: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_en_i && wr_data_i[MODE_BIT]) |=> (qtr_o && half_o));

   a_r9_inhibit_clears: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_en_i && wr_data_i[INH_BIT]) |=> !irq_o);

   a_r10_fall_cause: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(irq_o) |-> $past(clr_i || (wr_en_i && wr_data_i[INH_BIT])));

   a_r6_no_rise_five: assert property (@(posedge clk_i) disable iff (rst_i)
      five_seen |-> !$rose(irq_o));

endmodule

bind snd_frame_seq snd_frame_seq_chk #(
   .CTRL_W   (CTRL_W),
   .MODE_BIT (MODE_BIT),
   .INH_BIT  (INH_BIT)
) u_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .cyc_en_i  (cyc_en_i),
   .wr_en_i   (wr_en_i),
   .wr_data_i (wr_data_i),
   .clr_i     (clr_i),
   .qtr_o     (qtr_o),
   .half_o    (half_o),
   .irq_o     (irq_o)
);

// File: tb/tb_snd_frame_seq.sv
`timescale 1ns/1ps
module tb_snd_frame_seq;

   logic       clk = 1'b0;
   logic       rst;
   logic       cyc_en;
   logic       wr_en;
   logic [7:0] wr_data;
   logic       clr;
   logic       qtr, half, irq;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   snd_frame_seq dut (
      .clk_i     (clk),
      .rst_i     (rst),
      .cyc_en_i  (cyc_en),
      .wr_en_i   (wr_en),
      .wr_data_i (wr_data),
      .clr_i     (clr),
      .qtr_o     (qtr),
      .half_o    (half),
      .irq_o     (irq)
   );

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
         if (errors >= 50) finish_run();
      end
   endtask

   // behavioural reference model
   int m_k, m_tail;
   bit m_five, m_inh, m_flag, e_q, e_h;

   always @(posedge clk) begin
      bit nq, nh, set;
      if (rst) begin
         m_k = 0; m_tail = 0; m_five = 0; m_inh = 0; m_flag = 0; e_q = 0; e_h = 0;
      end else begin
         nq = 0; nh = 0; set = 0;
         if (clr) m_flag = 0;
         if (wr_en) begin
            m_five = wr_data[7];
            m_inh  = wr_data[6];
            m_k    = 0;
            m_tail = 0;
            if (m_inh) m_flag = 0;
            if (m_five) begin nq = 1; nh = 1; end
         end else if (cyc_en) begin
            m_k++;
            if (!m_five) begin
               if (m_k == 7459 || m_k == 14915 || m_k == 22373 || m_k == 29830) nq = 1;
               if (m_k == 14915 || m_k == 29830) nh = 1;
               if (m_tail > 0) begin set = 1; m_tail--; end
               if (m_k == 29830) begin set = 1; m_tail = 2; m_k = 0; end
            end else begin
               if (m_k == 7459 || m_k == 14915 || m_k == 22373 || m_k == 37283) nq = 1;
               if (m_k == 7459 || m_k == 22373) nh = 1;
               if (m_k == 37283) m_k = 0;
            end
            if (set && !m_inh) m_flag = 1;
         end
         e_q = nq; e_h = nh;
      end
   end

   int  q_cnt = 0, h_cnt = 0;
   bit  irq_seen = 0;

   always @(negedge clk) begin
      if (!rst && !done) begin
         check(qtr == e_q, m_five ? "R4 qtr_o vs model" : "R3 qtr_o vs model", qtr, e_q);
         check(half == e_h, m_five ? "R4 half_o vs model" : "R3 half_o vs model", half, e_h);
         check(irq == m_flag, "R5 irq_o vs model", irq, m_flag);
         if (qtr) q_cnt++;
         if (half) h_cnt++;
         if (irq) irq_seen = 1;
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic write_ctrl(input logic [7:0] d);
      wr_en = 1; wr_data = d;
      tick();
      wr_en = 0; wr_data = 8'h00;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      finish_run();
   end

   initial begin
      int n, first_q;
      rst = 1; cyc_en = 0; wr_en = 0; wr_data = 8'h00; clr = 0;
      repeat (4) tick();
      check(qtr == 0 && half == 0, "R1 strobes low in reset", qtr, 0);
      check(irq == 0, "R1 irq low in reset", irq, 0);
      rst = 0; cyc_en = 1;

      // four-step from reset, up to the first flag
      q_cnt = 0; h_cnt = 0; n = 0; first_q = -1;
      while (!irq) begin
         tick(); n++;
         if (qtr && first_q < 0) first_q = n;
      end
      check(first_q == 7459, "R1 first strobe distance", first_q, 7459);
      check(n == 29830, "R5 flag rises at count", n, 29830);
      check(q_cnt == 4, "R3 quarters per loop", q_cnt, 4);
      check(h_cnt == 2, "R3 halves per loop", h_cnt, 2);

      // clear coinciding with the two tail sets, then plain clear
      clr = 1;
      tick();
      check(irq == 1, "R10 set wins over clear (count 1)", irq, 1);
      tick();
      check(irq == 1, "R10 set wins over clear (count 2)", irq, 1);
      tick();
      check(irq == 0, "R10 clear drops flag", irq, 0);
      clr = 0;

      // enable held low, then gapped
      cyc_en = 0; q_cnt = 0; h_cnt = 0; irq_seen = 0;
      repeat (5000) tick();
      check(q_cnt == 0, "R2 no strobe with enable low", q_cnt, 0);
      check(irq_seen == 0, "R2 no flag with enable low", irq_seen, 0);
      for (int i = 0; i < 6000; i++) begin
         cyc_en = i[0];
         tick();
      end
      cyc_en = 1;
      while (!irq) tick();
      check(q_cnt == 4, "R2 quarters with gapped enable", q_cnt, 4);
      check(h_cnt == 2, "R2 halves with gapped enable", h_cnt, 2);

      // write with inhibit clear keeps the flag and restarts
      write_ctrl(8'h00);
      check(irq == 1, "R9 inhibit-clear write keeps flag", irq, 1);
      n = 0;
      while (!qtr) begin tick(); n++; end
      check(n == 7459, "R7 R11 restart distance to first step", n, 7459);

      // inhibit write clears and blocks setting
      write_ctrl(8'h40);
      check(irq == 0, "R9 inhibit write clears flag", irq, 0);
      q_cnt = 0; irq_seen = 0;
      repeat (30000) tick();
      check(irq_seen == 0, "R6 no flag while inhibited", irq_seen, 0);
      check(q_cnt == 4, "R3 quarters while inhibited", q_cnt, 4);

      // five-step mode
      q_cnt = 0; h_cnt = 0; irq_seen = 0;
      write_ctrl(8'h80);
      check(qtr == 1, "R8 immediate quarter", qtr, 1);
      check(half == 1, "R8 immediate half", half, 1);
      repeat (37283) tick();
      check(q_cnt == 5, "R4 quarters over one loop", q_cnt, 5);
      check(h_cnt == 3, "R4 halves over one loop", h_cnt, 3);
      check(irq_seen == 0, "R6 no flag in five-step", irq_seen, 0);

      repeat (10) tick();
      finish_run();
   end

endmodule